// File: doc/BRIEF.md
# DRAM Bank Timing Scheduler

This block manages a single DRAM bank on behalf of a read-only client. It keeps track of whether a row is open and which one it is. Each read request carries a row and a column. The block turns it into the shortest legal command sequence on a small command bus:

- a READ alone when the open row matches (row hit);
- an ACTIVATE then a READ when the bank is closed;
- a PRECHARGE, then an ACTIVATE, then a READ when a different row is open (row conflict).

Rows stay open after a read, so this is an open-page policy.

Four delays are programmable through configuration inputs, all in clock cycles:

- the read-to-data delay;
- the activate-to-read delay;
- the precharge-to-activate delay;
- the minimum time a row must stay open before it may be precharged.

A command-rate input selects whether two commands may issue on consecutive cycles or must be at least two cycles apart. Returned data is represented by a one-cycle strobe. The strobe comes with the request's class and with its measured latency.

Requests use a valid/ready handshake, and only one request is in flight at a time. The reported latency is the number of cycles from the first command slot after acceptance to the strobe. For an unstalled request this equals the hit, closed or conflict formula. A stall caused by the minimum open time or by the command rate adds its cycles to the reported latency.

Top module: `dram_bank_sched`

## Requirements
- R1: While `rst_n` is low, `cmd_code` is NOP (0), `data_valid` is 0 and `req_ready` is 0. Within three cycles of release `req_ready` is 1, and no row is open, so the first request is classified closed.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the `data_valid` cycle and is high again in the following cycle.
- R3: A row hit (`rsp_kind` = 0) issues READ (`cmd_code` = 2) in the first slot after acceptance. With no command-rate stall, its latency is CL.
- R4: A closed-bank access (`rsp_kind` = 1) issues ACTIVATE (`cmd_code` = 1) first and READ no earlier than tRCD cycles later. Its latency is tRCD+CL.
- R5: A row conflict (`rsp_kind` = 2) issues PRECHARGE (`cmd_code` = 3), then ACTIVATE tRP cycles later, then READ tRCD cycles after that. Its latency is tRP+tRCD+CL.
- R6: A PRECHARGE is never issued less than tRAS cycles after the ACTIVATE of the open row. A conflict that arrives earlier waits, and the wait is included in the reported latency.
- R7: `data_valid` is a one-cycle pulse exactly CL cycles after the READ.
- R8: With `cfg_cmd2t` = 1, two non-NOP commands are never on adjacent cycles, and any command that would otherwise follow after one cycle is delayed by one cycle. With `cfg_cmd2t` = 0, commands may issue back to back.
- R9: `rsp_latency`, valid with `data_valid`, equals the number of cycles from the first cycle after acceptance to the `data_valid` cycle.
- R10: `cmd_row` carries the request row when ACTIVATE issues, and `cmd_col` carries the request column when READ issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cl | input | TW | Read-to-data delay in cycles |
| cfg_trcd | input | TW | Activate-to-read delay in cycles |
| cfg_trp | input | TW | Precharge-to-activate delay in cycles |
| cfg_tras | input | TW | Minimum activate-to-precharge time in cycles |
| cfg_cmd2t | input | 1 | 1 = at least two cycles between commands |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cmd_code | output | 2 | 0 NOP, 1 ACTIVATE, 2 READ, 3 PRECHARGE |
| cmd_row | output | ROW_W | Row for ACTIVATE |
| cmd_col | output | COL_W | Column for READ |
| data_valid | output | 1 | Modelled first-data strobe |
| rsp_kind | output | 2 | 0 hit, 1 closed, 2 conflict; valid with data_valid |
| rsp_latency | output | LAT_W | Measured latency; valid with data_valid |

## Verification
The assertions assume that every timing input is at least one cycle. They also assume that configuration does not change while a request is outstanding, because the counters are loaded from the live inputs and an open row's tRAS window comes from the value present when it was activated. The bench follows these rules. It sweeps every combination of small delay values from one upward together with both command rates. For each combination it resets the block, changes the configuration only while reset is held, and then drives a closed, hit, conflict, hit, conflict request pattern. That pattern makes conflicts arrive both inside and after the tRAS window.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam logic [1:0] CMD_NOP = 2'd0;
  localparam logic [1:0] CMD_ACT = 2'd1;
  localparam logic [1:0] CMD_RD  = 2'd2;
  localparam logic [1:0] CMD_PRE = 2'd3;

  localparam logic [1:0] KIND_HIT      = 2'd0;
  localparam logic [1:0] KIND_CLOSED   = 2'd1;
  localparam logic [1:0] KIND_CONFLICT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACT  = 3'd2,
    ST_RD   = 3'd3,
    ST_DATA = 3'd4
  } bank_st_e;
endpackage

// File: rtl/dbs_cnt.sv
module dbs_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    if (load)            cnt_nxt = ld_val;
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
    else                 cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dbs_lat.sv
module dbs_lat #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             busy,
  output logic [LAT_W-1:0] lat
);
  logic [LAT_W-1:0] lat_nxt;
  logic             lat_en;

  assign lat_en = clr | (busy & (lat != '1));

  always_comb begin
    if (clr) lat_nxt = '0;
    else     lat_nxt = lat + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat <= '0;
    else if (lat_en) lat <= lat_nxt;
  end
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int TW    = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    cfg_cl,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_tras,
  input  logic             cfg_cmd2t,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             data_valid,
  output logic [1:0]       rsp_kind,
  output logic             accept,
  output logic             busy
);
  localparam int SW = TW + 1;

  bank_st_e         st_q, st_nxt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [1:0]       kind_q, kind_nxt;
  logic             open_q;
  logic [ROW_W-1:0] open_row_q;

  logic             dly_ld, ras_ld, gap_ld;
  logic [TW-1:0]    dly_val;
  logic [TW-1:0]    dly_cnt, ras_cnt;
  logic [0:0]       gap_cnt;
  logic             dly_zero, ras_zero, gap_zero;

  function automatic logic [TW-1:0] dec1(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  dbs_cnt #(.W(TW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_ld), .ld_val(dly_val),
    .cnt(dly_cnt), .zero(dly_zero)
  );

  dbs_cnt #(.W(TW)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(ras_ld), .ld_val(dec1(cfg_tras)),
    .cnt(ras_cnt), .zero(ras_zero)
  );

  dbs_cnt #(.W(1)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_ld), .ld_val(cfg_cmd2t),
    .cnt(gap_cnt), .zero(gap_zero)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign busy      = (st_q != ST_IDLE);
  assign gap_ld    = (cmd_code != CMD_NOP);
  assign cmd_row   = row_q;
  assign cmd_col   = col_q;
  assign rsp_kind  = kind_q;

  always_comb begin
    st_nxt     = st_q;
    kind_nxt   = kind_q;
    cmd_code   = CMD_NOP;
    dly_ld     = 1'b0;
    dly_val    = '0;
    ras_ld     = 1'b0;
    data_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (!open_q) begin
            st_nxt   = ST_ACT;
            kind_nxt = KIND_CLOSED;
          end else if (open_row_q == req_row) begin
            st_nxt   = ST_RD;
            kind_nxt = KIND_HIT;
          end else begin
            st_nxt   = ST_PRE;
            kind_nxt = KIND_CONFLICT;
          end
        end
      end
      ST_PRE: begin
        if (ras_zero && gap_zero) begin
          cmd_code = CMD_PRE;
          dly_ld   = 1'b1;
          dly_val  = dec1(cfg_trp);
          st_nxt   = ST_ACT;
        end
      end
      ST_ACT: begin
        if (dly_zero && gap_zero) begin
          cmd_code = CMD_ACT;
          dly_ld   = 1'b1;
          dly_val  = dec1(cfg_trcd);
          ras_ld   = 1'b1;
          st_nxt   = ST_RD;
        end
      end
      ST_RD: begin
        if (dly_zero && gap_zero) begin
          cmd_code = CMD_RD;
          dly_ld   = 1'b1;
          dly_val  = dec1(cfg_cl);
          st_nxt   = ST_DATA;
        end
      end
      ST_DATA: begin
        if (dly_zero) begin
          data_valid = 1'b1;
          st_nxt     = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= KIND_HIT;
    end else begin
      st_q   <= st_nxt;
      kind_q <= kind_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      row_q <= req_row;
      col_q <= req_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else if (cmd_code == CMD_ACT) begin
      open_q     <= 1'b1;
      open_row_q <= row_q;
    end else if (cmd_code == CMD_PRE) begin
      open_q     <= 1'b0;
    end
  end

  // Independent elapsed-time counters used only by the checks below
  logic [SW-1:0] since_act, since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_rd  <= '1;
    end else begin
      if (cmd_code == CMD_ACT)  since_act <= SW'(1);
      else if (since_act != '1) since_act <= since_act + 1'b1;
      if (cmd_code == CMD_RD)   since_rd  <= SW'(1);
      else if (since_rd != '1)  since_rd  <= since_rd + 1'b1;
    end
  end

  // R6
  pre_after_tras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |-> (since_act >= {1'b0, cfg_tras}));

  // R4
  rd_after_trcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD && kind_q != KIND_HIT) |-> (since_act >= {1'b0, cfg_trcd}));

  // R7
  data_at_cl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (since_rd == {1'b0, cfg_cl}));

  // R7
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R8
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != CMD_NOP && cfg_cmd2t) |=> (cmd_code == CMD_NOP));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
  parameter int TW    = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    cfg_cl,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_tras,
  input  logic             cfg_cmd2t,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             data_valid,
  output logic [1:0]       rsp_kind,
  output logic [LAT_W-1:0] rsp_latency
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       accept, busy, ready_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dbs_ctrl #(.TW(TW), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_cmd2t(cfg_cmd2t),
    .req_valid(req_valid), .req_ready(ready_int),
    .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .data_valid(data_valid), .rsp_kind(rsp_kind),
    .accept(accept), .busy(busy)
  );

  assign req_ready = ready_int & rst_int_n;

  dbs_lat #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_int_n), .clr(accept), .busy(busy),
    .lat(rsp_latency)
  );
endmodule

// File: tb/sim_dram_bank_sched.sv
module sim_dram_bank_sched;
  localparam int TW = 4, ROW_W = 8, COL_W = 6, LAT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [TW-1:0]    cfg_cl, cfg_trcd, cfg_trp, cfg_tras;
  logic             cfg_cmd2t;
  logic             req_valid;
  logic             req_ready;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [1:0]       cmd_code;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             data_valid;
  logic [1:0]       rsp_kind;
  logic [LAT_W-1:0] rsp_latency;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit m_open;
  int m_row, m_act, m_last;

  dram_bank_sched #(.TW(TW), .ROW_W(ROW_W), .COL_W(COL_W), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_cmd2t(cfg_cmd2t),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .data_valid(data_valid), .rsp_kind(rsp_kind), .rsp_latency(rsp_latency)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cl=%0d trcd=%0d trp=%0d tras=%0d 2t=%0d)",
               req, act, exp, cfg_cl, cfg_trcd, cfg_trp, cfg_tras, cfg_cmd2t);
    end
  endtask

  task automatic do_reset(input bit verbose);
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    if (verbose) begin
      chk(cmd_code == 2'd0, "R1 reset cmd", cmd_code, 0);
      chk(data_valid == 1'b0, "R1 reset data_valid", data_valid, 0);
      chk(req_ready == 1'b0, "R1 reset ready", req_ready, 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    if (verbose) chk(req_ready == 1'b1, "R1 ready after release", req_ready, 1);
    m_open = 1'b0; m_row = 0; m_act = -1000; m_last = -1000;
  endtask

  task automatic do_req(input int row, input int col);
    int acc, cr, kind, t_pre, t_act, t_rd, t_dv, guard;
    int bad_cyc, bad_code, exp_code, seen_dv_cyc;
    bit seq_ok, row_ok, col_ok, stall;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col);
    guard = 0;
    while (!req_ready && guard < 300) begin @(negedge clk); guard++; end
    acc = cyc + 1;
    cr = cfg_cmd2t ? 2 : 1;
    t_pre = -1; t_act = -1; stall = 1'b0;
    if (!m_open) begin
      kind = 1; tag = "R4";
      t_act = imax(acc, m_last + cr);
      t_rd  = t_act + imax(int'(cfg_trcd), cr);
    end else if (m_row == row) begin
      kind = 0; tag = "R3";
      t_rd = imax(acc, m_last + cr);
    end else begin
      kind = 2; tag = "R5";
      stall = (m_act + int'(cfg_tras) > acc);
      t_pre = imax(imax(acc, m_act + int'(cfg_tras)), m_last + cr);
      t_act = t_pre + imax(int'(cfg_trp), cr);
      t_rd  = t_act + imax(int'(cfg_trcd), cr);
    end
    if (stall) tag = {tag, " R6"};
    if (cfg_cmd2t) tag = {tag, " R8"};
    t_dv = t_rd + int'(cfg_cl);
    if (t_act >= 0) m_act = t_act;
    m_last = t_rd; m_open = 1'b1; m_row = row;

    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);

    seq_ok = 1'b1; row_ok = 1'b1; col_ok = 1'b1;
    bad_cyc = 0; bad_code = 0; seen_dv_cyc = -1; guard = 0;
    while (guard < 300) begin
      exp_code = (cyc == t_pre) ? 3 : (cyc == t_act) ? 1 : (cyc == t_rd) ? 2 : 0;
      if (int'(cmd_code) != exp_code && seq_ok) begin
        seq_ok = 1'b0; bad_cyc = cyc; bad_code = int'(cmd_code);
      end
      if (cmd_code == 2'd1 && int'(cmd_row) != row) row_ok = 1'b0;
      if (cmd_code == 2'd2 && int'(cmd_col) != col) col_ok = 1'b0;
      if (data_valid) begin seen_dv_cyc = cyc; break; end
      if (cyc > acc) chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      @(negedge clk);
      guard++;
    end
    chk(seq_ok, {tag, " command sequence"}, bad_code, bad_cyc - acc);
    chk(seen_dv_cyc == t_dv, "R7 data_valid cycle", seen_dv_cyc - acc, t_dv - acc);
    chk(int'(rsp_latency) == t_dv - acc, {"R9 ", tag, " latency"}, rsp_latency, t_dv - acc);
    chk(int'(rsp_kind) == kind, {tag, " kind"}, rsp_kind, kind);
    chk(row_ok && col_ok, "R10 command address", {row_ok, col_ok}, 3);
    @(negedge clk);
    chk(data_valid == 1'b0, "R7 single-cycle strobe", data_valid, 0);
    chk(req_ready == 1'b1, "R2 ready after data", req_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_row = '0; req_col = '0;
    cfg_cl = 4'd2; cfg_trcd = 4'd2; cfg_trp = 4'd2; cfg_tras = 4'd4; cfg_cmd2t = 1'b0;
    do_reset(1'b1);
    for (int cr2 = 0; cr2 < 2; cr2++) begin
      for (int tras_i = 0; tras_i < 3; tras_i++) begin
        for (int cl = 1; cl <= 3; cl++) begin
          for (int rcd = 1; rcd <= 3; rcd++) begin
            for (int rp = 1; rp <= 3; rp++) begin
              @(negedge clk);
              rst_n = 1'b0;
              cfg_cl = TW'(cl); cfg_trcd = TW'(rcd); cfg_trp = TW'(rp);
              cfg_tras = (tras_i == 0) ? 4'd1 : (tras_i == 1) ? 4'd4 : 4'd12;
              cfg_cmd2t = cr2[0];
              do_reset(1'b0);
              do_req(1, 5);
              do_req(1, 6);
              do_req(2, 7);
              do_req(2, 3);
              do_req(1, 0);
            end
          end
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule